// File: doc/BRIEF.md
# Register-Bound Multi-Stream Instruction Fetcher

This block feeds a core with instructions from up to eight concurrent instruction streams. Each stream sits in a fetch line. A line holds the virtual page and word position it is fetching, the physical page that the translation port returned for it, and one buffered instruction word. Every line is bound to an architectural register number. A jump names a register. If a line is already bound to that register, delivery switches to it and carries on from where that stream stopped. A conditional jump to a saved register therefore works as a return. If no line is bound to the register, the least recently used line is taken over and restarted at the register's address.

A prefetch command names a register in the same way. It starts filling a line ahead of the jump without disturbing the stream that is being delivered. Translation comes through a read-only lookup port. Instruction words come through a cache read port. Both ports use a request held until a one-cycle acknowledge. A line issues a fresh lookup whenever its word position wraps into the next page. Delivery uses a valid/ready pair that carries the virtual PC and the instruction word.

Top module: `fetch_lines`

## Requirements
- R1: While reset is held and after it is released, with no command given, `out_valid`, `tlb_req` and `ic_req` stay low.
- R2: A jump or prefetch whose register is bound to no line takes over the line with the oldest age (age 7 of 0..7). After reset the ages equal the line indices, so line 7 is taken first.
- R3: Ages are updated on every jump, and on every prefetch that takes over a line. The touched line gets age 0, and each line younger than the touched line's old age grows older by one. A jump to a recently touched register therefore finds its line still resident.
- R4: Each delivered `out_word` is the cache word at the physical address formed by the translated page of `out_pc` (upper bits) concatenated with the low OFF_W bits of `out_pc`. A response that belongs to a line reloaded while the request was outstanding is discarded.
- R5: Consecutive words delivered from one line have PCs that increase by one word, modulo 2^(VPN_W+OFF_W).
- R6: After the last word of a page is delivered, the line looks up the next virtual page, and nothing more is delivered from that line until the new translation and its word have returned.
- R7: A jump to a register that is bound to a line resumes that line's stream at its next PC. The address given with the command is ignored.
- R8: A jump to an unbound register binds it to the taken line and restarts delivery at the given address. `out_valid` is low in the cycle after the jump.
- R9: A prefetch (`cmd_op`=1) does not change the delivered stream. A prefetch to a register that is already bound changes neither the line nor the ages.
- R10: A prefetch that takes over the line currently being delivered stops delivery (`out_valid` low) until the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 1 | 0 = jump, 1 = prefetch |
| cmd_reg | input | REG_W | Register number named by the command |
| cmd_va | input | VPN_W+OFF_W | Word address held in that register |
| tlb_req | output | 1 | Translation request, held until acknowledged |
| tlb_vpn | output | VPN_W | Virtual page to translate |
| tlb_ack | input | 1 | Translation done, one cycle |
| tlb_ppn | input | PPN_W | Physical page returned |
| ic_req | output | 1 | Cache read request, held until acknowledged |
| ic_addr | output | PPN_W+OFF_W | Physical word address |
| ic_ack | input | 1 | Cache word returned, one cycle |
| ic_word | input | WORD_W | Returned instruction word |
| out_valid | output | 1 | Delivered instruction valid |
| out_ready | input | 1 | Consumer accepts the delivered instruction |
| out_pc | output | VPN_W+OFF_W | Virtual PC of the delivered instruction |
| out_word | output | WORD_W | Delivered instruction word |

## Verification
The hardest state to reach from the ports is a prefetch that takes over the line currently being delivered. That line must first become the oldest of the eight, which takes seven age updates that each land on a different line, while the active stream itself is left untouched. The directed phase binds eight registers, jumps back to one of them, and then issues seven prefetches to fresh registers before an eighth prefetch takes over the active line. A bench model of bindings and ages then predicts every hit and miss during a long random phase. In that phase the responders reply after random delays, and reloads, page crossings and stalls on the consumer side collide.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic {
    OP_JUMP     = 1'b0,
    OP_PREFETCH = 1'b1
  } fl_op_e;
endpackage

// File: rtl/fl_lru.sv
module fl_lru #(
  parameter int NL = 8,
  parameter int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [LW-1:0] touch_idx,
  output logic [LW-1:0] victim_idx
);
  logic [LW-1:0] age_q [NL];
  logic [LW-1:0] age_d [NL];
  logic [NL-1:0] is_old;
  logic [LW-1:0] ref_age;

  always_comb begin
    ref_age = age_q[touch_idx];
    victim_idx = '0;
    for (int i = 0; i < NL; i++) begin
      is_old[i] = (age_q[i] == LW'(NL - 1));
      if (is_old[i]) victim_idx = LW'(i);
      age_d[i] = age_q[i];
      if (LW'(i) == touch_idx) age_d[i] = '0;
      else if (age_q[i] < ref_age) age_d[i] = age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) age_q[i] <= LW'(i);
    end else if (touch) begin
      for (int i = 0; i < NL; i++) age_q[i] <= age_d[i];
    end
  end

  // R2: exactly one line carries the oldest age
  p_one_oldest_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot(is_old));

  for (genvar g = 0; g < NL; g++) begin : g_age_chk
    // R3: touched line becomes youngest
    p_touch_young_r3: assert property (@(posedge clk) disable iff (!rst_n)
      touch && touch_idx == LW'(g) |=> age_q[g] == '0);
    // R3: younger lines age by one
    p_touch_older_r3: assert property (@(posedge clk) disable iff (!rst_n)
      touch && touch_idx != LW'(g) && age_q[g] < age_q[touch_idx]
      |=> age_q[g] == $past(age_q[g]) + 1'b1);
  end
endmodule

// File: rtl/fl_line.sv
module fl_line #(
  parameter int REG_W  = 5,
  parameter int VPN_W  = 16,
  parameter int OFF_W  = 4,
  parameter int PPN_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [REG_W-1:0]       load_reg,
  input  logic [VPN_W+OFF_W-1:0] load_va,
  input  logic                   tlb_done,
  input  logic [PPN_W-1:0]       tlb_ppn,
  input  logic                   ic_done,
  input  logic [WORD_W-1:0]      ic_word,
  input  logic                   pop,
  output logic                   valid,
  output logic [REG_W-1:0]       bound_reg,
  output logic                   need_tlb,
  output logic                   need_ic,
  output logic                   full,
  output logic [VPN_W+OFF_W-1:0] pc,
  output logic [VPN_W-1:0]       vpn,
  output logic [PPN_W+OFF_W-1:0] ic_addr,
  output logic [WORD_W-1:0]      word
);
  localparam int VA_W = VPN_W + OFF_W;

  logic              valid_q, valid_d;
  logic [REG_W-1:0]  reg_q, reg_d;
  logic [VPN_W-1:0]  vpn_q, vpn_d;
  logic [OFF_W-1:0]  cnt_q, cnt_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic              xl_ok_q, xl_ok_d;
  logic              full_q, full_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              upd;

  always_comb begin
    valid_d = valid_q; reg_d = reg_q; vpn_d = vpn_q; cnt_d = cnt_q;
    ppn_d = ppn_q; xl_ok_d = xl_ok_q; full_d = full_q; word_d = word_q;
    if (load) begin
      valid_d = 1'b1;
      reg_d   = load_reg;
      vpn_d   = load_va[VA_W-1:OFF_W];
      cnt_d   = load_va[OFF_W-1:0];
      xl_ok_d = 1'b0;
      full_d  = 1'b0;
    end else begin
      if (tlb_done && !xl_ok_q) begin
        ppn_d   = tlb_ppn;
        xl_ok_d = 1'b1;
      end
      if (ic_done && xl_ok_q && !full_q) begin
        word_d = ic_word;
        full_d = 1'b1;
      end
      if (pop && full_q) begin
        full_d = 1'b0;
        cnt_d  = cnt_q + 1'b1;
        if (&cnt_q) begin
          vpn_d   = vpn_q + 1'b1;
          xl_ok_d = 1'b0;
        end
      end
    end
  end

  assign upd = load | tlb_done | ic_done | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0; reg_q <= '0; vpn_q <= '0; cnt_q <= '0;
      ppn_q <= '0; xl_ok_q <= 1'b0; full_q <= 1'b0; word_q <= '0;
    end else if (upd) begin
      valid_q <= valid_d; reg_q <= reg_d; vpn_q <= vpn_d; cnt_q <= cnt_d;
      ppn_q <= ppn_d; xl_ok_q <= xl_ok_d; full_q <= full_d; word_q <= word_d;
    end
  end

  assign valid     = valid_q;
  assign bound_reg = reg_q;
  assign need_tlb  = valid_q && !xl_ok_q;
  assign need_ic   = valid_q && xl_ok_q && !full_q;
  assign full      = full_q;
  assign pc        = {vpn_q, cnt_q};
  assign vpn       = vpn_q;
  assign ic_addr   = {ppn_q, cnt_q};
  assign word      = word_q;

  // R8: a reload empties the line and forces a fresh translation
  p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q && !full_q && !xl_ok_q);
  // R5: a delivered word advances the PC by one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && full_q && !load |=> pc == $past(pc) + 1'b1);
  // R6: wrapping into the next page demands a new lookup
  p_page_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && full_q && (&cnt_q) && !load |=> need_tlb && !full_q);
endmodule

// File: rtl/fetch_lines.sv
module fetch_lines #(
  parameter int NLINES = 8,
  parameter int REG_W  = 5,
  parameter int VPN_W  = 16,
  parameter int OFF_W  = 4,
  parameter int PPN_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_op,
  input  logic [REG_W-1:0]       cmd_reg,
  input  logic [VPN_W+OFF_W-1:0] cmd_va,
  output logic                   tlb_req,
  output logic [VPN_W-1:0]       tlb_vpn,
  input  logic                   tlb_ack,
  input  logic [PPN_W-1:0]       tlb_ppn,
  output logic                   ic_req,
  output logic [PPN_W+OFF_W-1:0] ic_addr,
  input  logic                   ic_ack,
  input  logic [WORD_W-1:0]      ic_word,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [VPN_W+OFF_W-1:0] out_pc,
  output logic [WORD_W-1:0]      out_word
);
  import fl_pkg::*;

  localparam int LW   = $clog2(NLINES);
  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic [NLINES-1:0] valid_v, need_tlb_v, need_ic_v, full_v, hit_v;
  logic [NLINES-1:0] load_v, pop_v, tlb_done_v, ic_done_v;
  logic [REG_W-1:0]  reg_a   [NLINES];
  logic [VA_W-1:0]   pc_a    [NLINES];
  logic [VPN_W-1:0]  vpn_a   [NLINES];
  logic [PA_W-1:0]   icadr_a [NLINES];
  logic [WORD_W-1:0] word_a  [NLINES];

  logic          hit_any, tlb_any, ic_any, is_pref, do_load, touch, pop;
  logic [LW-1:0] hit_idx, tlb_pick, ic_pick, victim_idx, tgt_idx;

  logic          act_ok_q, act_ok_d;
  logic [LW-1:0] act_q, act_d;
  logic          tb_busy_q, tb_busy_d, tb_drop_q, tb_drop_d;
  logic [LW-1:0] tb_own_q, tb_own_d;
  logic          ic_busy_q, ic_busy_d, ic_drop_q, ic_drop_d;
  logic [LW-1:0] ic_own_q, ic_own_d;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    fl_line #(
      .REG_W(REG_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .WORD_W(WORD_W)
    ) u_line (
      .clk(clk), .rst_n(rst_n),
      .load(load_v[g]), .load_reg(cmd_reg), .load_va(cmd_va),
      .tlb_done(tlb_done_v[g]), .tlb_ppn(tlb_ppn),
      .ic_done(ic_done_v[g]), .ic_word(ic_word),
      .pop(pop_v[g]),
      .valid(valid_v[g]), .bound_reg(reg_a[g]),
      .need_tlb(need_tlb_v[g]), .need_ic(need_ic_v[g]), .full(full_v[g]),
      .pc(pc_a[g]), .vpn(vpn_a[g]), .ic_addr(icadr_a[g]), .word(word_a[g])
    );
    assign hit_v[g]      = valid_v[g] && (reg_a[g] == cmd_reg);
    assign load_v[g]     = do_load && (victim_idx == LW'(g));
    assign pop_v[g]      = pop && (act_q == LW'(g));
    assign tlb_done_v[g] = tb_busy_q && tlb_ack && !tb_drop_q && (tb_own_q == LW'(g));
    assign ic_done_v[g]  = ic_busy_q && ic_ack && !ic_drop_q && (ic_own_q == LW'(g));
  end

  fl_lru #(.NL(NLINES), .LW(LW)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(tgt_idx), .victim_idx(victim_idx)
  );

  // lowest index wins each search
  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    tlb_any = 1'b0; tlb_pick = '0;
    ic_any  = 1'b0; ic_pick  = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (hit_v[i])      begin hit_any = 1'b1; hit_idx  = LW'(i); end
      if (need_tlb_v[i]) begin tlb_any = 1'b1; tlb_pick = LW'(i); end
      if (need_ic_v[i])  begin ic_any  = 1'b1; ic_pick  = LW'(i); end
    end
  end

  assign is_pref = (fl_op_e'(cmd_op) == OP_PREFETCH);
  assign tgt_idx = hit_any ? hit_idx : victim_idx;
  assign do_load = cmd_valid && !hit_any;
  assign touch   = cmd_valid && !(is_pref && hit_any);

  assign out_valid = act_ok_q && full_v[act_q];
  assign out_pc    = pc_a[act_q];
  assign out_word  = word_a[act_q];
  assign pop       = out_valid && out_ready;

  // delivery selection
  always_comb begin
    act_d    = act_q;
    act_ok_d = act_ok_q;
    if (cmd_valid && !is_pref) begin
      act_d    = tgt_idx;
      act_ok_d = 1'b1;
    end else if (do_load && is_pref && victim_idx == act_q) begin
      act_ok_d = 1'b0;
    end
  end

  // translation and cache request owners
  always_comb begin
    tb_busy_d = tb_busy_q; tb_own_d = tb_own_q; tb_drop_d = tb_drop_q;
    if (tb_busy_q) begin
      if (tlb_ack) begin
        tb_busy_d = 1'b0; tb_drop_d = 1'b0;
      end else if (load_v[tb_own_q]) begin
        tb_drop_d = 1'b1;
      end
    end else if (tlb_any) begin
      tb_busy_d = 1'b1; tb_own_d = tlb_pick; tb_drop_d = load_v[tlb_pick];
    end
    ic_busy_d = ic_busy_q; ic_own_d = ic_own_q; ic_drop_d = ic_drop_q;
    if (ic_busy_q) begin
      if (ic_ack) begin
        ic_busy_d = 1'b0; ic_drop_d = 1'b0;
      end else if (load_v[ic_own_q]) begin
        ic_drop_d = 1'b1;
      end
    end else if (ic_any) begin
      ic_busy_d = 1'b1; ic_own_d = ic_pick; ic_drop_d = load_v[ic_pick];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0; act_ok_q <= 1'b0;
      tb_busy_q <= 1'b0; tb_own_q <= '0; tb_drop_q <= 1'b0;
      ic_busy_q <= 1'b0; ic_own_q <= '0; ic_drop_q <= 1'b0;
    end else begin
      act_q <= act_d; act_ok_q <= act_ok_d;
      tb_busy_q <= tb_busy_d; tb_own_q <= tb_own_d; tb_drop_q <= tb_drop_d;
      ic_busy_q <= ic_busy_d; ic_own_q <= ic_own_d; ic_drop_q <= ic_drop_d;
    end
  end

  assign tlb_req = tb_busy_q;
  assign tlb_vpn = vpn_a[tb_own_q];
  assign ic_req  = ic_busy_q;
  assign ic_addr = icadr_a[ic_own_q];

  // R6: a lookup request stays up until acknowledged
  p_tlb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req && !tlb_ack |=> tlb_req);
  // R4: a cache request stays up until acknowledged
  p_ic_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ic_req && !ic_ack |=> ic_req);
  // R8: a jump that misses stalls delivery on the next cycle
  p_miss_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !is_pref && !hit_any |=> !out_valid);
  // R9: a prefetch leaves a stalled delivered word in place
  p_pref_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_pref && out_valid && !out_ready && !(do_load && victim_idx == act_q)
    |=> out_valid && $stable(out_pc));
  // R10: taking over the delivered line blanks the output
  p_evict_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && is_pref && !hit_any && victim_idx == act_q |=> !out_valid);
endmodule

// File: tb/sim_fetch_lines.sv
`timescale 1ns/1ps
module sim_fetch_lines;
  localparam int NL = 8, REG_W = 5, VPN_W = 16, OFF_W = 4, PPN_W = 12, WORD_W = 32;
  localparam int VA_W = VPN_W + OFF_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [REG_W-1:0] cmd_reg = '0;
  logic [VA_W-1:0] cmd_va = '0;
  logic tlb_req, ic_req, out_valid;
  logic [VPN_W-1:0] tlb_vpn;
  logic tlb_ack = 1'b0, ic_ack = 1'b0, out_ready = 1'b0;
  logic [PPN_W-1:0] tlb_ppn = '0;
  logic [PA_W-1:0] ic_addr;
  logic [WORD_W-1:0] ic_word = '0, out_word;
  logic [VA_W-1:0] out_pc;

  always #4 clk = ~clk;

  fetch_lines #(.NLINES(NL), .REG_W(REG_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
                .PPN_W(PPN_W), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_reg(cmd_reg), .cmd_va(cmd_va), .tlb_req(tlb_req), .tlb_vpn(tlb_vpn),
    .tlb_ack(tlb_ack), .tlb_ppn(tlb_ppn), .ic_req(ic_req), .ic_addr(ic_addr),
    .ic_ack(ic_ack), .ic_word(ic_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_word(out_word));

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  function automatic logic [PPN_W-1:0] ppn_of(logic [VPN_W-1:0] v);
    return PPN_W'(v * 16'd13 + 16'd5);
  endfunction
  function automatic logic [WORD_W-1:0] word_of(logic [PA_W-1:0] pa);
    return WORD_W'({pa, pa} * 32'h9E3779B1) ^ 32'hA5A5_0F0F;
  endfunction
  function automatic logic [WORD_W-1:0] exp_word(logic [VA_W-1:0] pc);
    return word_of({ppn_of(pc[VA_W-1:OFF_W]), pc[OFF_W-1:0]});
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // memory responders with random latency
  int tw = 1, cw = 2;
  always @(negedge clk) begin
    tlb_ack = 1'b0;
    ic_ack  = 1'b0;
    if (rst_n && tlb_req) begin
      if (tw == 0) begin
        tlb_ack = 1'b1; tlb_ppn = ppn_of(tlb_vpn); tw = int'($urandom % 4);
      end else tw--;
    end
    if (rst_n && ic_req) begin
      if (cw == 0) begin
        ic_ack = 1'b1; ic_word = word_of(ic_addr); cw = int'($urandom % 4);
      end else cw--;
    end
  end

  // reference model
  bit              m_val [NL];
  logic [REG_W-1:0] m_reg [NL];
  logic [VA_W-1:0] m_pc  [NL];
  int              m_age [NL];
  string           m_tag [NL];
  int              m_act = 0;
  bit              m_act_ok = 1'b0;
  string           dark_tag = "R1";
  bit              stall_chk = 1'b0;
  bit              last_pop = 1'b0;

  task automatic step(bit cv, bit pf, logic [REG_W-1:0] rg, logic [VA_W-1:0] va,
                      bit rdy, string tag);
    int hit, tgt, old;
    @(negedge clk);
    if (stall_chk) begin
      chk(!out_valid, "R8", out_valid, 0);
      stall_chk = 1'b0;
    end
    if (!m_act_ok && out_valid) chk(1'b0, dark_tag, out_valid, 0);
    last_pop = out_valid && rdy && m_act_ok;
    if (last_pop) begin
      chk(out_pc == m_pc[m_act], m_tag[m_act], out_pc, m_pc[m_act]);
      chk(out_word == exp_word(m_pc[m_act]), "R4", out_word, exp_word(m_pc[m_act]));
      m_pc[m_act] = m_pc[m_act] + 1'b1;
      m_tag[m_act] = (m_pc[m_act][OFF_W-1:0] == '0) ? "R6" : "R5";
    end
    if (cv) begin
      hit = -1;
      for (int i = NL - 1; i >= 0; i--) if (m_val[i] && m_reg[i] == rg) hit = i;
      if (!(pf && hit >= 0)) begin
        tgt = hit;
        if (hit < 0) begin
          for (int i = 0; i < NL; i++) if (m_age[i] == NL - 1) tgt = i;
          m_val[tgt] = 1'b1; m_reg[tgt] = rg; m_pc[tgt] = va;
          m_tag[tgt] = (tag != "") ? tag : "R8";
          if (pf && tgt == m_act && m_act_ok) begin
            m_act_ok = 1'b0; dark_tag = "R10";
          end
          if (!pf) stall_chk = 1'b1;
        end else begin
          m_tag[tgt] = (tag != "") ? tag : "R7";
        end
        old = m_age[tgt];
        for (int i = 0; i < NL; i++) begin
          if (i == tgt) m_age[i] = 0;
          else if (m_age[i] < old) m_age[i]++;
        end
        if (!pf) begin m_act = tgt; m_act_ok = 1'b1; end
      end
    end
    cmd_valid = cv; cmd_op = pf; cmd_reg = rg; cmd_va = va; out_ready = rdy;
  endtask

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, '0, '0, rdy, "");
  endtask

  task automatic run_pops(int n);
    int got = 0;
    while (got < n) begin
      step(0, 0, '0, '0, 1'b1, "");
      if (last_pop) got++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NL; i++) begin
      m_val[i] = 1'b0; m_reg[i] = '0; m_pc[i] = '0; m_age[i] = i; m_tag[i] = "R5";
    end
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1", out_valid, 0);
    chk(!tlb_req, "R1", tlb_req, 0);
    chk(!ic_req, "R1", ic_req, 0);
    rst_n = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(!out_valid && !tlb_req && !ic_req, "R1", {out_valid, tlb_req, ic_req}, 0);
    end

    // page crossing from the first stream
    step(1, 0, 5'd1, 20'h0123E, 1'b1, "");
    run_pops(6);
    // bind registers 2..8, each miss filling the next oldest line
    for (int r = 2; r <= 8; r++) begin
      step(1, 0, 5'(r), 20'(r * 20'h01010 + 20'h0000D), 1'b1, "R2");
      run_pops(3);
    end
    // return to register 1: its stream resumes, address ignored
    step(1, 0, 5'd1, 20'hFFFF0, 1'b1, "R7");
    run_pops(2);
    // prefetch to a bound register is ignored; the oldest line stays the victim
    step(1, 1, 5'd2, 20'h77770, 1'b1, "R9");
    run_pops(2);
    step(1, 1, 5'd9, 20'h3333F, 1'b1, "R9");
    run_pops(2);
    step(1, 0, 5'd2, 20'h50000, 1'b1, "R2");
    run_pops(3);
    step(1, 0, 5'd1, 20'h12345, 1'b1, "R3");
    run_pops(2);
    step(1, 1, 5'd1, 20'h0AAAA, 1'b0, "");
    step(1, 0, 5'd1, 20'h0BBBB, 1'b1, "R9");
    run_pops(2);
    // age the active line out with prefetches, then take it over
    for (int r = 20; r < 27; r++) begin
      step(1, 1, 5'(r), 20'(r * 20'h00777), 1'b1, "R9");
      run_pops(1);
    end
    step(1, 1, 5'd27, 20'h4444E, 1'b1, "R9");
    for (int i = 0; i < 4; i++) begin
      step(0, 0, '0, '0, 1'b1, "");
      chk(!out_valid, "R10", out_valid, 0);
    end
    step(1, 0, 5'd1, 20'h0FFFE, 1'b1, "R8");
    run_pops(4);
    step(1, 0, 5'd27, 20'h00000, 1'b1, "R7");
    run_pops(3);

    // random phase
    for (int i = 0; i < 20000; i++) begin
      bit cv, pf, rdy;
      logic [VA_W-1:0] va;
      cv  = ($urandom % 8) == 0;
      pf  = ($urandom % 3) == 0;
      rdy = ($urandom % 4) != 0;
      va  = VA_W'($urandom);
      if ($urandom % 3 == 0) va[OFF_W-1:0] = 4'hC + 4'($urandom % 4);
      step(cv, pf, 5'($urandom % 12), va, rdy, "");
    end
    idle(10, 1'b1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule